// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host bus and an embedded flash array controller. It watches the host's write strobe cycles and recognises the multi-cycle command sequences that drive the array: byte program, sector and bulk erase, erase suspend and resume, protection query, return to read, and a fast-program bypass mode. Each recognised command becomes a single-cycle request pulse to the array controller, along with the address, data or sector mask that the command carries.

A write is framed by the active-low strobe `wr_n`. The address is captured when the strobe falls and the data when it rises. The completed write is decoded one cycle after the rising edge. Only the low twelve address bits take part in decoding. Sector erase gathers further sectors during a timed window and issues the erase when the window runs out. The `rd_mode` output and the query outputs let the surrounding read path choose between array data and protection status.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Only `addr[11:0]` is compared in decoding. An unlock write of AAh at F555h is accepted the same as one at 0555h.
- R2: The sequence AAh@555h, 55h@AAAh, A0h@555h, then any write, gives exactly one `prog_go` pulse. `prog_addr` and `prog_data` hold the full address and the data of that last write.
- R3: The unlock pair followed by 90h@555h sets `rd_mode` to 01 (query). In query mode, a bus address with `addr[7:0]`=02h raises `qry_hit`, and `qry_data` is 01h if any selected sector is protected and 00h otherwise. A write of F0h returns `rd_mode` to 00 (array).
- R4: The sequence AAh@555h, 55h@AAAh, 80h@555h, AAh@555h, 55h@AAAh, then 30h while at least one `sect_sel` bit is high, opens an erase window of WIN_CYC cycles. `erase_go` pulses only when the window expires, with `erase_bulk`=0 and `erase_mask` equal to the selected sectors.
- R5: Each 30h write inside an open window that has a sector selected ORs that selection into the mask and restarts the window.
- R6: The same five leading cycles followed by 10h@555h pulse `erase_go` at once, with every `erase_mask` bit set and `erase_bulk`=1.
- R7: A single B0h write in array mode pulses `susp_go` only while `erase_busy`=1 and `erase_susp`=0.
- R8: A single 30h write in array mode pulses `resume_go` only while `erase_susp`=1.
- R9: The unlock pair followed by 20h@555h sets `rd_mode` to 10 (bypass). In bypass mode, A0h at any address followed by any write gives one `prog_go`. 90h followed by 00h returns `rd_mode` to 00.
- R10: A write that breaks a sequence discards it and returns to the base state. That write is not decoded again as the start of a new sequence.
- R11: `prog_go`, `erase_go`, `susp_go` and `resume_go` last one cycle each, and at most one of them is high in any cycle.
- R12: The decoded address is the one present when `wr_n` falls, and the decoded data is the one present when `wr_n` rises. Changes to either input at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | BUS_AW | Bus address |
| wdata | input | 8 | Write data |
| sect_sel | input | NSECT | Active-high sector selects for the current address |
| sect_prot | input | NSECT | Per-sector protection status |
| erase_busy | input | 1 | Array controller is erasing |
| erase_susp | input | 1 | Array controller has an erase suspended |
| prog_go | output | 1 | Program request pulse |
| prog_addr | output | BUS_AW | Address to program |
| prog_data | output | 8 | Data to program |
| erase_go | output | 1 | Erase request pulse |
| erase_mask | output | NSECT | Sectors to erase |
| erase_bulk | output | 1 | Erase is a whole-array erase (valid with erase_go) |
| susp_go | output | 1 | Suspend request pulse |
| resume_go | output | 1 | Resume request pulse |
| rd_mode | output | 2 | 00 array, 01 query, 10 bypass |
| qry_hit | output | 1 | Current read is a protection-status read |
| qry_data | output | 8 | Protection status byte |

## Verification
The case that is hardest to reach is the restart of the erase window. It needs a complete six-write erase sequence, then a second 30h write to a different sector that lands well inside the window but long after it opened. The bench waits about half a window between the two erase writes. It then checks that no erase has been issued at a time when the first window alone would already have expired. Finally it checks that the single erase that does arrive carries both sectors in its mask.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int DEC_AW = 12;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'b00,
        MODE_QUERY  = 2'b01,
        MODE_BYPASS = 2'b10
    } rd_mode_e;

    typedef enum logic [3:0] {
        ST_BASE,
        ST_U1,
        ST_U2,
        ST_PROG,
        ST_E80,
        ST_EU1,
        ST_EU2,
        ST_COLLECT,
        ST_BPX
    } seq_state_e;

    localparam logic [7:0] CD_UNLK1  = 8'hAA;
    localparam logic [7:0] CD_UNLK2  = 8'h55;
    localparam logic [7:0] CD_QUERY  = 8'h90;
    localparam logic [7:0] CD_PROG   = 8'hA0;
    localparam logic [7:0] CD_ERSETUP = 8'h80;
    localparam logic [7:0] CD_SECT   = 8'h30;
    localparam logic [7:0] CD_BULK   = 8'h10;
    localparam logic [7:0] CD_SUSP   = 8'hB0;
    localparam logic [7:0] CD_RESET  = 8'hF0;
    localparam logic [7:0] CD_BYPASS = 8'h20;
    localparam logic [7:0] CD_BPEXIT = 8'h00;

    localparam logic [DEC_AW-1:0] AD_A = 12'h555;
    localparam logic [DEC_AW-1:0] AD_B = 12'hAAA;

    function automatic logic hit(input logic [7:0] d, input logic [DEC_AW-1:0] a,
                                 input logic [7:0] dc, input logic [DEC_AW-1:0] ac);
        return (d == dc) && (a == ac);
    endfunction

endpackage

// File: rtl/flash_wr_capture.sv
module flash_wr_capture #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          evt_vld,
    output logic [AW-1:0] evt_addr,
    output logic [7:0]    evt_data
);
    logic          wr_q;
    logic [AW-1:0] addr_lat;
    logic          fall, rise;

    assign fall = wr_q & ~wr_n;
    assign rise = ~wr_q & wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q     <= 1'b1;
            addr_lat <= '0;
            evt_vld  <= 1'b0;
            evt_addr <= '0;
            evt_data <= '0;
        end else begin
            wr_q    <= wr_n;
            evt_vld <= rise;
            if (fall) addr_lat <= addr;
            if (rise) begin
                evt_addr <= addr_lat;
                evt_data <= wdata;
            end
        end
    end
endmodule

// File: rtl/flash_win_timer.sv
module flash_win_timer #(
    parameter int WIN_CYC = 8000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expire
);
    localparam int CW = $clog2(WIN_CYC + 1);

    logic [CW-1:0] cnt;
    logic          run;

    assign expire = run && !start && (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= CW'(WIN_CYC);
            run <= 1'b1;
        end else if (run) begin
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) run <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW    = 16,
    parameter int NSECT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_vld,
    input  logic [AW-1:0]    evt_addr,
    input  logic [7:0]       evt_data,
    input  logic [NSECT-1:0] sect_sel,
    input  logic             erase_busy,
    input  logic             erase_susp,
    input  logic             win_expire,
    output logic             win_start,
    output logic             prog_go,
    output logic [AW-1:0]    prog_addr,
    output logic [7:0]       prog_data,
    output logic             erase_go,
    output logic [NSECT-1:0] erase_mask,
    output logic             erase_bulk,
    output logic             susp_go,
    output logic             resume_go,
    output rd_mode_e         mode
);
    seq_state_e          st;
    logic [NSECT-1:0]    acc_mask;
    logic [DEC_AW-1:0]   a;
    logic [7:0]          d;
    logic                any_sel;

    assign a       = evt_addr[DEC_AW-1:0];
    assign d       = evt_data;
    assign any_sel = |sect_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_BASE;
            mode       <= MODE_ARRAY;
            acc_mask   <= '0;
            win_start  <= 1'b0;
            prog_go    <= 1'b0;
            prog_addr  <= '0;
            prog_data  <= '0;
            erase_go   <= 1'b0;
            erase_mask <= '0;
            erase_bulk <= 1'b0;
            susp_go    <= 1'b0;
            resume_go  <= 1'b0;
        end else begin
            prog_go    <= 1'b0;
            erase_go   <= 1'b0;
            erase_bulk <= 1'b0;
            susp_go    <= 1'b0;
            resume_go  <= 1'b0;
            win_start  <= 1'b0;
            if (st == ST_COLLECT && win_expire) begin
                erase_go   <= 1'b1;
                erase_mask <= acc_mask;
                st         <= ST_BASE;
            end else if (evt_vld) begin
                unique case (st)
                    ST_BASE: begin
                        unique case (mode)
                            MODE_QUERY: begin
                                if (d == CD_RESET) mode <= MODE_ARRAY;
                            end
                            MODE_BYPASS: begin
                                if (d == CD_PROG)       st <= ST_PROG;
                                else if (d == CD_QUERY) st <= ST_BPX;
                            end
                            default: begin
                                if (hit(d, a, CD_UNLK1, AD_A)) st <= ST_U1;
                                else if (d == CD_SUSP)    susp_go   <= erase_busy && !erase_susp;
                                else if (d == CD_SECT)    resume_go <= erase_susp;
                            end
                        endcase
                    end
                    ST_U1: st <= hit(d, a, CD_UNLK2, AD_B) ? ST_U2 : ST_BASE;
                    ST_U2: begin
                        st <= ST_BASE;
                        if (a == AD_A) begin
                            if (d == CD_QUERY)        mode <= MODE_QUERY;
                            else if (d == CD_PROG)    st   <= ST_PROG;
                            else if (d == CD_ERSETUP) st   <= ST_E80;
                            else if (d == CD_BYPASS)  mode <= MODE_BYPASS;
                        end
                    end
                    ST_PROG: begin
                        prog_go   <= 1'b1;
                        prog_addr <= evt_addr;
                        prog_data <= d;
                        st        <= ST_BASE;
                    end
                    ST_E80: st <= hit(d, a, CD_UNLK1, AD_A) ? ST_EU1 : ST_BASE;
                    ST_EU1: st <= hit(d, a, CD_UNLK2, AD_B) ? ST_EU2 : ST_BASE;
                    ST_EU2: begin
                        st <= ST_BASE;
                        if (d == CD_SECT && any_sel) begin
                            acc_mask  <= sect_sel;
                            win_start <= 1'b1;
                            st        <= ST_COLLECT;
                        end else if (hit(d, a, CD_BULK, AD_A)) begin
                            erase_go   <= 1'b1;
                            erase_bulk <= 1'b1;
                            erase_mask <= '1;
                        end
                    end
                    ST_COLLECT: begin
                        if (d == CD_SECT && any_sel) begin
                            acc_mask  <= acc_mask | sect_sel;
                            win_start <= 1'b1;
                        end
                    end
                    ST_BPX: begin
                        if (d == CD_BPEXIT) mode <= MODE_ARRAY;
                        st <= ST_BASE;
                    end
                    default: st <= ST_BASE;
                endcase
            end
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int BUS_AW = 16,
    parameter int NSECT  = 8,
    parameter int CLK_HZ = 100_000_000,
    parameter int WIN_US = 80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [NSECT-1:0]  sect_sel,
    input  logic [NSECT-1:0]  sect_prot,
    input  logic              erase_busy,
    input  logic              erase_susp,
    output logic              prog_go,
    output logic [BUS_AW-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              erase_go,
    output logic [NSECT-1:0]  erase_mask,
    output logic              erase_bulk,
    output logic              susp_go,
    output logic              resume_go,
    output logic [1:0]        rd_mode,
    output logic              qry_hit,
    output logic [7:0]        qry_data
);
    localparam int WIN_CYC = (CLK_HZ / 1_000_000) * WIN_US;

    logic              evt_vld;
    logic [BUS_AW-1:0] evt_addr;
    logic [7:0]        evt_data;
    logic              win_start, win_expire;
    rd_mode_e          mode;

    flash_wr_capture #(.AW(BUS_AW)) u_cap (
        .clk(clk), .rst(rst), .wr_n(wr_n), .addr(addr), .wdata(wdata),
        .evt_vld(evt_vld), .evt_addr(evt_addr), .evt_data(evt_data)
    );

    flash_win_timer #(.WIN_CYC(WIN_CYC)) u_win (
        .clk(clk), .rst(rst), .start(win_start), .expire(win_expire)
    );

    flash_seq_fsm #(.AW(BUS_AW), .NSECT(NSECT)) u_fsm (
        .clk(clk), .rst(rst),
        .evt_vld(evt_vld), .evt_addr(evt_addr), .evt_data(evt_data),
        .sect_sel(sect_sel), .erase_busy(erase_busy), .erase_susp(erase_susp),
        .win_expire(win_expire), .win_start(win_start),
        .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_go(erase_go), .erase_mask(erase_mask), .erase_bulk(erase_bulk),
        .susp_go(susp_go), .resume_go(resume_go), .mode(mode)
    );

    assign rd_mode  = mode;
    assign qry_hit  = (mode == MODE_QUERY) && (addr[7:0] == 8'h02);
    assign qry_data = {7'b0, |(sect_sel & sect_prot)};
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int NSECT = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             erase_busy,
    input logic             erase_susp,
    input logic             prog_go,
    input logic             erase_go,
    input logic             erase_bulk,
    input logic [NSECT-1:0] erase_mask,
    input logic             susp_go,
    input logic             resume_go,
    input logic [1:0]       rd_mode,
    input logic             qry_hit
);
    AST_SUSP_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        susp_go |-> $past(erase_busy && !erase_susp)); // R7
    AST_RESUME_WHEN_SUSP: assert property (@(posedge clk) disable iff (rst)
        resume_go |-> $past(erase_susp)); // R8
    AST_ERASE_HAS_SECTOR: assert property (@(posedge clk) disable iff (rst)
        erase_go |-> (erase_mask != '0)); // R4
    AST_BULK_ALL_SECTORS: assert property (@(posedge clk) disable iff (rst)
        erase_bulk |-> (erase_go && (&erase_mask))); // R6
    AST_QUERY_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (rst)
        qry_hit |-> (rd_mode == 2'b01)); // R3
    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_go, erase_go, susp_go, resume_go})); // R11
    AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        prog_go |=> !prog_go); // R11
    AST_ERASE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        erase_go |=> !erase_go); // R11
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rd_mode != 2'b11); // R9
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.NSECT(NSECT)) u_chk (
    .clk(clk), .rst(rst), .erase_busy(erase_busy), .erase_susp(erase_susp),
    .prog_go(prog_go), .erase_go(erase_go), .erase_bulk(erase_bulk),
    .erase_mask(erase_mask), .susp_go(susp_go), .resume_go(resume_go),
    .rd_mode(rd_mode), .qry_hit(qry_hit)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
    localparam int AW = 16;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [NS-1:0] sect_sel = '0;
    logic [NS-1:0] sect_prot = '0;
    logic          erase_busy = 1'b0;
    logic          erase_susp = 1'b0;
    logic          prog_go, erase_go, erase_bulk, susp_go, resume_go, qry_hit;
    logic [AW-1:0] prog_addr;
    logic [7:0]    prog_data, qry_data;
    logic [NS-1:0] erase_mask;
    logic [1:0]    rd_mode;

    int n_chk = 0, n_err = 0;
    int n_prog = 0, n_erase = 0, n_susp = 0, n_res = 0;
    logic [AW-1:0] c_paddr;
    logic [7:0]    c_pdata;
    logic [NS-1:0] c_mask;
    logic          c_bulk;
    bit            done = 0;

    always #5 clk = ~clk;

    flash_cmd_decoder uut (
        .clk(clk), .rst(rst), .wr_n(wr_n), .addr(addr), .wdata(wdata),
        .sect_sel(sect_sel), .sect_prot(sect_prot),
        .erase_busy(erase_busy), .erase_susp(erase_susp),
        .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_go(erase_go), .erase_mask(erase_mask), .erase_bulk(erase_bulk),
        .susp_go(susp_go), .resume_go(resume_go), .rd_mode(rd_mode),
        .qry_hit(qry_hit), .qry_data(qry_data)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (prog_go)   begin n_prog++;  c_paddr = prog_addr; c_pdata = prog_data; end
            if (erase_go)  begin n_erase++; c_mask = erase_mask; c_bulk = erase_bulk; end
            if (susp_go)   n_susp++;
            if (resume_go) n_res++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // address valid at strobe fall, data valid at strobe rise; both scrambled otherwise
    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = 8'h5C; wr_n = 1'b0;
        @(negedge clk); addr = ~a; wdata = d;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); wdata = ~d; addr = 16'h0F0F;
        repeat (3) @(negedge clk);
    endtask

    task automatic unlock();
        bus_wr(16'h0555, 8'hAA);
        bus_wr(16'h0AAA, 8'h55);
    endtask

    task automatic t_reset();
        chk("R11 reset no pulses", {prog_go, erase_go, susp_go, resume_go}, 4'b0);
        chk("R3 reset mode array", rd_mode, 2'b00);
        chk("R3 reset no query", qry_hit, 1'b0);
    endtask

    task automatic t_program();
        bus_wr(16'hF555, 8'hAA);   // R1 high bits ignored
        bus_wr(16'h3AAA, 8'h55);
        bus_wr(16'h0555, 8'hA0);
        bus_wr(16'h1234, 8'h5A);
        chk("R2 program count", n_prog, 1);
        chk("R1 R12 program address", c_paddr, 16'h1234);
        chk("R2 R12 program data", c_pdata, 8'h5A);
    endtask

    task automatic t_query();
        unlock();
        bus_wr(16'h0555, 8'h90);
        chk("R3 query mode", rd_mode, 2'b01);
        sect_prot = 8'h02; sect_sel = 8'h02; addr = 16'h4002;
        @(negedge clk);
        chk("R3 query hit", qry_hit, 1'b1);
        chk("R3 protected", qry_data, 8'h01);
        sect_sel = 8'h01;
        @(negedge clk);
        chk("R3 unprotected", qry_data, 8'h00);
        sect_sel = 8'h00;
        bus_wr(16'h0000, 8'hF0);
        chk("R3 reset exits query", rd_mode, 2'b00);
    endtask

    task automatic t_sector_erase();
        unlock();
        bus_wr(16'h0555, 8'h80);
        unlock();
        sect_sel = 8'h01;
        bus_wr(16'h0100, 8'h30);
        sect_sel = 8'h00;
        repeat (4000) @(negedge clk);
        chk("R4 no erase early", n_erase, 0);
        sect_sel = 8'h04;
        bus_wr(16'h0400, 8'h30);
        sect_sel = 8'h00;
        repeat (7000) @(negedge clk);
        chk("R5 window restarted", n_erase, 0);
        repeat (1200) @(negedge clk);
        chk("R4 erase issued", n_erase, 1);
        chk("R5 merged mask", c_mask, 8'h05);
        chk("R4 not bulk", c_bulk, 1'b0);
    endtask

    task automatic t_bulk();
        unlock();
        bus_wr(16'h0555, 8'h80);
        unlock();
        bus_wr(16'h0555, 8'h10);
        chk("R6 bulk count", n_erase, 2);
        chk("R6 bulk mask", c_mask, 8'hFF);
        chk("R6 bulk flag", c_bulk, 1'b1);
    endtask

    task automatic t_susp_resume();
        bus_wr(16'h0000, 8'hB0);
        chk("R7 no suspend when idle", n_susp, 0);
        bus_wr(16'h0000, 8'h30);
        chk("R8 no resume when not suspended", n_res, 0);
        erase_busy = 1'b1;
        bus_wr(16'h0123, 8'hB0);
        chk("R7 suspend when busy", n_susp, 1);
        erase_susp = 1'b1;
        bus_wr(16'h0000, 8'hB0);
        chk("R7 no suspend when suspended", n_susp, 1);
        bus_wr(16'h0777, 8'h30);
        chk("R8 resume when suspended", n_res, 1);
        erase_busy = 1'b0; erase_susp = 1'b0;
    endtask

    task automatic t_bypass();
        unlock();
        bus_wr(16'h0555, 8'h20);
        chk("R9 bypass mode", rd_mode, 2'b10);
        bus_wr(16'h0777, 8'hA0);
        bus_wr(16'h0100, 8'h33);
        chk("R9 bypass program", n_prog, 2);
        chk("R9 bypass data", c_pdata, 8'h33);
        chk("R9 still bypass", rd_mode, 2'b10);
        bus_wr(16'h0000, 8'h90);
        bus_wr(16'h0000, 8'h00);
        chk("R9 bypass exit", rd_mode, 2'b00);
    endtask

    task automatic t_mismatch();
        bus_wr(16'h0555, 8'hAA);
        bus_wr(16'h0555, 8'h55);   // wrong address
        bus_wr(16'h0555, 8'h90);
        chk("R10 broken unlock", rd_mode, 2'b00);
        bus_wr(16'h0555, 8'hAA);
        bus_wr(16'h0555, 8'hAA);   // breaks; must not restart
        bus_wr(16'h0AAA, 8'h55);
        bus_wr(16'h0555, 8'hA0);
        bus_wr(16'h0200, 8'h77);
        chk("R10 no re-evaluation", n_prog, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_program();
        t_query();
        t_sector_erase();
        t_bulk();
        t_susp_resume();
        t_bypass();
        t_mismatch();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule